// File: doc/BRIEF.md
# Configurable Serializing Transmit Lane

This block turns a parallel word from a slow core clock domain into a single serial bit stream clocked by a fast bit clock. The fast clock runs at exactly SER_W times the slow clock frequency, and the two clocks are phase-aligned. A word is captured on each slow rising edge. It is moved into a shift register on the next fast edge and sent most significant bit first, one bit per fast cycle. Words follow each other with no gap.

The lane has three variants, chosen at compile time. In the data variant (SER_W from 2 to 8) it serializes `par_data`. In the reference-clock variant it ignores `par_data` and sends a forwarded clock pattern through the same shift path. This keeps the clock edges aligned with data lanes that use the same factor. The pattern runs at either the slow-clock rate or half of it. With SER_W set to 1 the serializer is left out, and the lane is a registered single-bit output with an output enable. A separate enable flag goes to the pad model.

Top module: `serial_tx_lane`

## Requirements
- R1: In the serialized variants, every slow-clock period sends exactly SER_W bits. Each bit is held on `ser_out` for one fast cycle, and the next word's first bit follows the previous word's last bit directly.
- R2: Bits are sent most significant first: `par_data[SER_W-1]` first and `par_data[0]` last.
- R3: A word present on `par_data` at a slow rising edge has its first bit on `ser_out` from the second fast rising edge at or after that slow edge. This edge is one fast cycle after the capture.
- R4: With SER_W = 1 the lane bypasses serialization. At each slow rising edge, `ser_out` becomes `par_data[0]` when `oe_in` is 1, and 0 (the idle value) when `oe_in` is 0.
- R5: With SER_W = 1, `pad_oe` takes the value of `oe_in` at each slow rising edge.
- R6: In the serialized variants, `oe_in` has no effect. `pad_oe` is 1 from the first fast edge after reset is released, and the serial data does not depend on `oe_in`.
- R7: In reference-clock mode with divide setting 1, every word period sends ceil(SER_W/2) ones followed by zeros (for SER_W = 5 the bits are 1,1,1,0,0).
- R8: In reference-clock mode with divide setting 2, word periods alternate between all ones and all zeros. The first period after reset is all ones.
- R9: While `rst` is high, `ser_out` and `pad_oe` are 0 from the first edge of the domain's clock. The shift register is cleared, so after release `ser_out` stays 0 until the first word is loaded. That word is the one captured at the first slow edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Bit clock, SER_W times the slow clock, phase-aligned |
| slow_clk | input | 1 | Word clock of the core domain |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| par_data | input | SER_W | Parallel word, captured on slow rising edges |
| oe_in | input | 1 | Output enable, honoured only when SER_W = 1 |
| ser_out | output | 1 | Registered serial (or bypassed) output bit |
| pad_oe | output | 1 | Registered enable flag for the pad model |

## Verification
The bench targets the seam between words. It checks the first bit, which must land one fast cycle after capture (a wrong handoff shifts the whole stream by a cycle), and the last bit, which must not be cut short or repeated when the next word loads. The values 4'h8 and 4'h1 expose a lane that sends the least significant bit first. A reset in the middle of a run checks that the cleared shift register leaks no stale bits and that the half-rate reference restarts on its all-ones word instead of continuing its old phase. Toggling `oe_in` on the serial lane shows whether the enable leaks into that variant. On the bypass lane, the bench checks that disabling forces the idle 0 rather than passing the data through.

// File: rtl/txl_pkg.sv
package txl_pkg;

  typedef enum logic [0:0] {
    LANE_DATA   = 1'b0,
    LANE_REFCLK = 1'b1
  } lane_mode_e;

  // Number of leading ones in a full-rate reference word: ceil(w/2).
  function automatic int unsigned lead_ones(input int unsigned w);
    return (w + 1) / 2;
  endfunction

endpackage

// File: rtl/txl_word_src.sv
// Slow-domain word source: captures core data, or builds the forwarded
// clock pattern, and flips a handoff flag once per slow period.
module txl_word_src
  import txl_pkg::*;
#(
  parameter int unsigned SER_W     = 4,
  parameter lane_mode_e  LANE_MODE = LANE_DATA,
  parameter int unsigned REF_DIV   = 1
)(
  input  logic             slow_clk,
  input  logic             rst,
  input  logic [SER_W-1:0] par_data,
  output logic [SER_W-1:0] word_q,
  output logic             flip_q
);

  localparam int unsigned      HI_BITS = lead_ones(SER_W);
  localparam logic [SER_W-1:0] REF_PAT = ~({SER_W{1'b1}} >> HI_BITS);

  logic [SER_W-1:0] next_word;

  if (LANE_MODE == LANE_DATA) begin : g_data
    assign next_word = par_data;
  end else if (REF_DIV == 2) begin : g_ref_half
    logic half_q;
    logic unused_pd;
    assign unused_pd = ^par_data;
    always_ff @(posedge slow_clk) begin
      if (rst) half_q <= 1'b0;
      else     half_q <= ~half_q;
    end
    assign next_word = half_q ? '0 : '1;
  end else begin : g_ref_full
    logic unused_pd;
    assign unused_pd = ^par_data;
    assign next_word = REF_PAT;
  end

  always_ff @(posedge slow_clk) begin
    if (rst) begin
      word_q <= '0;
      flip_q <= 1'b0;
    end else begin
      word_q <= next_word;
      flip_q <= ~flip_q;
    end
  end

endmodule

// File: rtl/txl_shifter.sv
// Fast-domain shifter: loads a word one fast cycle after each slow edge
// and sends it most significant bit first through a registered output.
module txl_shifter #(
  parameter int unsigned SER_W = 4
)(
  input  logic             fast_clk,
  input  logic             rst,
  input  logic             flip_q,
  input  logic [SER_W-1:0] word_q,
  output logic             load_o,
  output logic             ser_o,
  output logic             oe_o
);

  logic             seen_q;
  logic [SER_W-1:0] sh_q;

  assign load_o = flip_q ^ seen_q;

  always_ff @(posedge fast_clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      sh_q   <= '0;
      ser_o  <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      seen_q <= flip_q;
      oe_o   <= 1'b1;
      if (load_o) begin
        ser_o <= word_q[SER_W-1];
        sh_q  <= {word_q[SER_W-2:0], 1'b0};
      end else begin
        ser_o <= sh_q[SER_W-1];
        sh_q  <= {sh_q[SER_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/txl_bypass.sv
// Plain registered output with enable, used when no serialization is asked.
module txl_bypass (
  input  logic slow_clk,
  input  logic rst,
  input  logic d_in,
  input  logic oe_in,
  output logic q_out,
  output logic oe_out
);

  always_ff @(posedge slow_clk) begin
    if (rst) begin
      q_out  <= 1'b0;
      oe_out <= 1'b0;
    end else begin
      q_out  <= oe_in & d_in;
      oe_out <= oe_in;
    end
  end

endmodule

// File: rtl/serial_tx_lane.sv
module serial_tx_lane
  import txl_pkg::*;
#(
  parameter int unsigned SER_W     = 4,
  parameter lane_mode_e  LANE_MODE = LANE_DATA,
  parameter int unsigned REF_DIV   = 1
)(
  input  logic             fast_clk,
  input  logic             slow_clk,
  input  logic             rst,
  input  logic [SER_W-1:0] par_data,
  input  logic             oe_in,
  output logic             ser_out,
  output logic             pad_oe
);

  logic             load_w;
  logic [SER_W-1:0] word_q;
  logic             flip_q;

  if (SER_W == 1) begin : g_byp
    logic unused_fast;
    assign unused_fast = fast_clk;
    assign load_w = 1'b0;
    assign word_q = '0;
    assign flip_q = 1'b0;

    txl_bypass u_byp (
      .slow_clk (slow_clk),
      .rst      (rst),
      .d_in     (par_data[0]),
      .oe_in    (oe_in),
      .q_out    (ser_out),
      .oe_out   (pad_oe)
    );
  end else begin : g_ser
    logic unused_oe;
    assign unused_oe = oe_in;

    txl_word_src #(
      .SER_W     (SER_W),
      .LANE_MODE (LANE_MODE),
      .REF_DIV   (REF_DIV)
    ) u_src (
      .slow_clk (slow_clk),
      .rst      (rst),
      .par_data (par_data),
      .word_q   (word_q),
      .flip_q   (flip_q)
    );

    txl_shifter #(
      .SER_W (SER_W)
    ) u_shf (
      .fast_clk (fast_clk),
      .rst      (rst),
      .flip_q   (flip_q),
      .word_q   (word_q),
      .load_o   (load_w),
      .ser_o    (ser_out),
      .oe_o     (pad_oe)
    );
  end

endmodule

// File: rtl/serial_tx_lane_chk.sv
module serial_tx_lane_chk
  import txl_pkg::*;
#(
  parameter int unsigned SER_W     = 4,
  parameter lane_mode_e  LANE_MODE = LANE_DATA,
  parameter int unsigned REF_DIV   = 1
)(
  input logic             fast_clk,
  input logic             slow_clk,
  input logic             rst,
  input logic             oe_in,
  input logic             ser_out,
  input logic             pad_oe,
  input logic             load_w,
  input logic [SER_W-1:0] word_q
);

  if (SER_W > 1) begin : g_ser
    logic       live_q;
    logic       seen_q;
    logic [3:0] gap_q;
    logic       unused_chk;
    assign unused_chk = ^{oe_in, slow_clk};

    always_ff @(posedge fast_clk) begin
      if (rst) begin
        live_q <= 1'b0;
        seen_q <= 1'b0;
        gap_q  <= '0;
      end else begin
        live_q <= 1'b1;
        if (load_w) begin
          seen_q <= 1'b1;
          gap_q  <= '0;
        end else if (gap_q != 4'hF) begin
          gap_q <= gap_q + 4'd1;
        end
      end
    end

    // R6
    oe_forced_chk: assert property (@(posedge fast_clk) disable iff (rst)
      live_q |-> pad_oe);

    // R1
    word_period_chk: assert property (@(posedge fast_clk) disable iff (rst)
      (load_w && seen_q) |-> (gap_q == 4'(SER_W - 1)));

    // R2
    msb_first_chk: assert property (@(posedge fast_clk) disable iff (rst)
      load_w |=> (ser_out == $past(word_q[SER_W-1])));

    if (LANE_MODE == LANE_REFCLK && REF_DIV == 2) begin : g_half
      // R8
      half_rate_hold_chk: assert property (@(posedge fast_clk) disable iff (rst)
        !load_w |=> $stable(ser_out));
    end
  end else begin : g_byp
    logic unused_chk;
    assign unused_chk = ^{fast_clk, load_w, word_q};

    // R4
    byp_idle_chk: assert property (@(posedge slow_clk) disable iff (rst)
      !oe_in |=> (ser_out == 1'b0));

    // R5
    byp_oe_chk: assert property (@(posedge slow_clk) disable iff (rst)
      oe_in |=> pad_oe);
  end

endmodule

bind serial_tx_lane serial_tx_lane_chk #(
  .SER_W     (SER_W),
  .LANE_MODE (LANE_MODE),
  .REF_DIV   (REF_DIV)
) u_chk (
  .fast_clk (fast_clk),
  .slow_clk (slow_clk),
  .rst      (rst),
  .oe_in    (oe_in),
  .ser_out  (ser_out),
  .pad_oe   (pad_oe),
  .load_w   (load_w),
  .word_q   (word_q)
);

// File: tb/serial_tx_lane_bench.sv
`timescale 1ns/1ps
module serial_tx_lane_bench;
  import txl_pkg::*;

  logic fast_clk, slow4, slow5, rst;
  int   fcyc;
  logic [3:0] dat4;
  logic oe_d, byp_d, byp_oe;
  logic ser_d, poe_d, ser_r1, poe_r1, ser_r2, poe_r2, ser_b, poe_b;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    int   due;
    int   lane;
    logic val;
    int   req;
  } exp_t;
  exp_t sb_q[$];

  // clocks: 125 MHz bit clock, word clocks aligned to its rising edges
  initial begin
    fast_clk = 0; slow4 = 0; slow5 = 0; fcyc = 0;
    forever begin
      #4;
      fcyc++;
      if (fcyc % 4 == 0) slow4 = 1; else if (fcyc % 4 == 2) slow4 = 0;
      if (fcyc % 5 == 0) slow5 = 1; else if (fcyc % 5 == 2) slow5 = 0;
      fast_clk = 1;
      #4 fast_clk = 0;
    end
  end

  serial_tx_lane #(.SER_W(4), .LANE_MODE(LANE_DATA), .REF_DIV(1)) u_serial_tx_lane (
    .fast_clk(fast_clk), .slow_clk(slow4), .rst(rst), .par_data(dat4),
    .oe_in(oe_d), .ser_out(ser_d), .pad_oe(poe_d));

  serial_tx_lane #(.SER_W(5), .LANE_MODE(LANE_REFCLK), .REF_DIV(1)) u_ref1 (
    .fast_clk(fast_clk), .slow_clk(slow5), .rst(rst), .par_data(5'b0),
    .oe_in(1'b0), .ser_out(ser_r1), .pad_oe(poe_r1));

  serial_tx_lane #(.SER_W(4), .LANE_MODE(LANE_REFCLK), .REF_DIV(2)) u_ref2 (
    .fast_clk(fast_clk), .slow_clk(slow4), .rst(rst), .par_data(4'b0),
    .oe_in(1'b0), .ser_out(ser_r2), .pad_oe(poe_r2));

  serial_tx_lane #(.SER_W(1), .LANE_MODE(LANE_DATA), .REF_DIV(1)) u_byp (
    .fast_clk(fast_clk), .slow_clk(slow4), .rst(rst), .par_data(byp_d),
    .oe_in(byp_oe), .ser_out(ser_b), .pad_oe(poe_b));

  function automatic logic lane_val(input int lane);
    case (lane)
      0: return ser_d;
      1: return ser_r1;
      2: return ser_r2;
      3: return ser_b;
      4: return poe_b;
      5: return poe_d;
      6: return poe_r1;
      default: return poe_r2;
    endcase
  endfunction

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input int r, input int lane);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s lane=%0d cycle=%0d actual=%b expected=%b",
               req_name(r), lane, fcyc, act, exp);
    end
  endtask

  task automatic push(input int due, input int lane, input logic val, input int r);
    exp_t e;
    e.due = due; e.lane = lane; e.val = val; e.req = r;
    sb_q.push_back(e);
  endtask

  // monitor: compare every expected item in the fast cycle it is due
  always @(negedge fast_clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == fcyc) begin
        check(lane_val(sb_q[i].lane), sb_q[i].val, sb_q[i].req, sb_q[i].lane);
        sb_q.delete(i);
      end
    end
  end

  task automatic to_edge(input int e);
    while (fcyc < e) @(posedge fast_clk);
    #1;
  endtask

  // expected reference patterns from release edge r up to cycle lim
  task automatic arm_ref(input int r, input int lim);
    for (int d = r + 1; d <= r + 5; d++) push(d, 1, 1'b0, 9);   // R9 cleared shifter
    for (int d = r + 1; d <= r + 4; d++) begin
      push(d, 0, 1'b0, 9);
      push(d, 2, 1'b0, 9);
    end
    for (int j = 0; j < 40; j++) begin
      for (int i = 0; i < 5; i++)                                // R7
        if (r + 6 + 5*j + i <= lim) push(r + 6 + 5*j + i, 1, (i < 3), 7);
      for (int i = 0; i < 4; i++)                                // R8
        if (r + 5 + 4*j + i <= lim) push(r + 5 + 4*j + i, 2, (j % 2 == 0), 8);
    end
  endtask

  // driver: called 1 ns after a slow4 edge; returns 1 ns after the next one
  task automatic send_word(input logic [3:0] w, input logic bd, input logic boe,
                           input logic doe);
    int c;
    c = fcyc;
    dat4 = w; byp_d = bd; byp_oe = boe; oe_d = doe;
    for (int i = 0; i < 4; i++)   // R3 first bit, R2 order, R1 last bit
      push(c + 5 + i, 0, w[3-i], (i == 0) ? 3 : ((i == 3) ? 1 : 2));
    push(c + 4, 3, boe & bd, 4);  // R4
    push(c + 4, 4, boe, 5);       // R5
    push(c + 4, 5, 1'b1, 6);      // R6
    @(posedge slow4);
    #1;
  endtask

  logic [3:0] pats [12];

  initial begin
    pats = '{4'hB, 4'h0, 4'hF, 4'h8, 4'h1, 4'h6, 4'h9, 4'hA, 4'h5, 4'h3, 4'hC, 4'h7};
    rst = 1; dat4 = 0; oe_d = 0; byp_d = 0; byp_oe = 0;
    for (int l = 0; l < 8; l++) push(12, l, 1'b0, 9);   // R9 reset state

    to_edge(40);
    rst = 0;
    arm_ref(40, 100);
    for (int j = 0; j < 12; j++)
      send_word(pats[j], j[0], j[1], j[2]);

    // mid-run reset
    to_edge(100);
    rst = 1;
    for (int d = 101; d <= 118; d++) begin              // R9
      push(d, 0, 1'b0, 9); push(d, 1, 1'b0, 9); push(d, 2, 1'b0, 9);
      push(d, 5, 1'b0, 9); push(d, 6, 1'b0, 9);
      if (d >= 104) begin push(d, 3, 1'b0, 9); push(d, 4, 1'b0, 9); end
    end

    to_edge(120);
    rst = 0;
    arm_ref(120, 200);
    for (int j = 0; j < 8; j++)
      send_word(pats[j] ^ 4'hF, ~j[0], ~j[1], ~j[0]);

    to_edge(205);
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 unconsumed expectations actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog expired actual=%0d expected=205", fcyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule